// File: doc/BRIEF.md
# I2C Serial Clock Generator with Bus Synchronization

This block produces the serial clock of an I2C controller as an open-drain style drive request. The low and high periods are programmed in system clock cycles. The block does not run a free divider. Each phase boundary follows the filtered SCL level that the block senses on the bus. A slave that holds the line low lengthens the low phase. Another master that pulls the line low ends the high phase early. Because of this, several masters can share one wired clock, and slaves can stretch it.

There are two period pairs. One serves the standard, fast and fast-plus speeds, and the other serves the high-speed mode. A mode input selects between them. The selection and the period values are captured only when a low phase begins. The data shift logic receives two single-cycle strobes: one when the block itself pulls the clock low, and one when it senses the clock going high.

Top module: `scl_clkgen`

## Requirements
- R1: While `rst` is high, or in the cycle after `en` is sampled low, `scl_oe` (1 = pull low, 0 = release), `fall_pulse` and `rise_pulse` are all 0. On the first clock edge with `en` high, the block starts a low phase, so `scl_oe` is 1 from the cycle after that edge.
- R2: A low phase keeps `scl_oe` at 1 for the effective low count, counting only cycles in which `scl_in` is sensed low. With a bus that follows the drive at once, `scl_oe` stays at 1 for exactly that many cycles.
- R3: After release, the high count starts at the first clock edge that senses `scl_in` high, and it lasts the effective high count. With an immediate bus, `scl_oe` stays at 0 for high+1 cycles. If the bus is held low externally until the S-th sampled released cycle (S ≥ 1), `scl_oe` stays at 0 for S+high cycles.
- R4: If `scl_in` is sensed low during the high count, the block drives low from the next cycle. If the external pull starts in released cycle k (2 ≤ k ≤ high), the released run is exactly k cycles. The low count that follows is a full low count.
- R5: When `hs_sel` is 1, the block uses the `hs_lo`/`hs_hi` pair. When it is 0, the block uses the `std_lo`/`std_hi` pair.
- R6: The mode select and the period values are captured at each clock edge that starts a low phase. A change in the middle of a phase leaves the current low and high phases unchanged and applies from the next low phase.
- R7: A programmed period of 0 has the same effect as a period of 1.
- R8: `fall_pulse` is 1 for exactly the first cycle of each low drive that the block starts on its own, whether at enable or at the end of a high count. It stays 0 when the low drive comes from an external pull during the high count, and it is never 1 at the same time as `rise_pulse`.
- R9: `rise_pulse` is 1 for one cycle, starting in the cycle after the first edge that senses `scl_in` high following a release. With an immediate bus, this is the second released cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; when low, the clock is released and the state is cleared |
| std_lo | input | CNT_W | Low period, normal speeds, in cycles |
| std_hi | input | CNT_W | High period, normal speeds, in cycles |
| hs_lo | input | CNT_W | Low period, high-speed mode, in cycles |
| hs_hi | input | CNT_W | High period, high-speed mode, in cycles |
| hs_sel | input | 1 | 1 selects the high-speed pair |
| scl_in | input | 1 | Filtered sensed SCL level |
| scl_oe | output | 1 | 1 = pull SCL low, 0 = release |
| fall_pulse | output | 1 | Strobe for a low drive started by the block |
| rise_pulse | output | 1 | Strobe for a sensed rising edge |

## Verification
The first pattern is a full sweep of low and high values from 0 to 4 in both modes. The bus follows the drive at once, and the run lengths are compared with max(v,1) and max(v,1)+1. This separates the zero-clamping, the pair selection and the one-cycle sensing delay. The second pattern holds the line low for a few extra cycles after release. It shows that the high count waits for a sensed high instead of starting at release. The third pattern pulls the line low partway through the high count. It separates an early abort from a completed count and checks that no fall strobe appears. The last pattern toggles the mode select during a low phase to show where the new pair takes effect.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;
endpackage

// File: rtl/scl_period_sel.sv
module scl_period_sel #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic             hs_sel,
  input  logic [CNT_W-1:0] std_lo,
  input  logic [CNT_W-1:0] std_hi,
  input  logic [CNT_W-1:0] hs_lo,
  input  logic [CNT_W-1:0] hs_hi,
  output logic [CNT_W-1:0] lo_lim,
  output logic [CNT_W-1:0] hi_lim
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] clamp1(input logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  logic [CNT_W-1:0] lo_pick, hi_pick;

  always_comb begin
    lo_pick = hs_sel ? hs_lo : std_lo;
    hi_pick = hs_sel ? hs_hi : std_hi;
  end

  // Both limits are captured together when a low phase begins.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lo_lim <= ONE;
      hi_lim <= ONE;
    end else if (load) begin
      lo_lim <= clamp1(lo_pick);
      hi_lim <= clamp1(hi_pick);
    end
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_clkgen_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] lo_lim,
  input  logic [CNT_W-1:0] hi_lim,
  output logic             load,
  output logic             oe,
  output logic             fall_p,
  output logic             rise_p
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  scl_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             lo_done, hi_done;

  always_comb begin
    lo_done = (cnt_q == lo_lim - ONE);
    hi_done = (cnt_q == hi_lim - ONE);
    load    = en && ((phase_q == PH_IDLE) ||
                     ((phase_q == PH_HIGH) && (!scl_in || hi_done)));
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      oe      <= 1'b0;
      fall_p  <= 1'b0;
      rise_p  <= 1'b0;
    end else begin
      fall_p <= 1'b0;
      rise_p <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          phase_q <= PH_LOW;
          oe      <= 1'b1;
          fall_p  <= 1'b1;
          cnt_q   <= '0;
        end
        PH_LOW: begin
          // Count only once the bus is really seen low.
          if (!scl_in) begin
            if (lo_done) begin
              phase_q <= PH_WAIT;
              oe      <= 1'b0;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + ONE;
            end
          end
        end
        PH_WAIT: begin
          // Stretching: hold here until the line reads high.
          if (scl_in) begin
            phase_q <= PH_HIGH;
            rise_p  <= 1'b1;
            cnt_q   <= '0;
          end
        end
        PH_HIGH: begin
          if (!scl_in) begin
            phase_q <= PH_LOW;
            oe      <= 1'b1;
            cnt_q   <= '0;
          end else if (hi_done) begin
            phase_q <= PH_LOW;
            oe      <= 1'b1;
            fall_p  <= 1'b1;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + ONE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] std_lo,
  input  logic [CNT_W-1:0] std_hi,
  input  logic [CNT_W-1:0] hs_lo,
  input  logic [CNT_W-1:0] hs_hi,
  input  logic             hs_sel,
  input  logic             scl_in,
  output logic             scl_oe,
  output logic             fall_pulse,
  output logic             rise_pulse
);
  logic             load;
  logic [CNT_W-1:0] lo_lim, hi_lim;

  scl_period_sel #(.CNT_W(CNT_W)) u_sel (
    .clk    (clk),
    .rst    (rst),
    .clr    (!en),
    .load   (load),
    .hs_sel (hs_sel),
    .std_lo (std_lo),
    .std_hi (std_hi),
    .hs_lo  (hs_lo),
    .hs_hi  (hs_hi),
    .lo_lim (lo_lim),
    .hi_lim (hi_lim)
  );

  scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .scl_in (scl_in),
    .lo_lim (lo_lim),
    .hi_lim (hi_lim),
    .load   (load),
    .oe     (scl_oe),
    .fall_p (fall_pulse),
    .rise_p (rise_pulse)
  );
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic scl_in,
  input logic scl_oe,
  input logic fall_pulse,
  input logic rise_pulse
);
  p_release_when_off_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!scl_oe && !fall_pulse && !rise_pulse));

  p_fall_with_drive_r8: assert property (@(posedge clk) disable iff (rst)
    fall_pulse |-> (scl_oe && !$past(scl_oe)));

  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(fall_pulse && rise_pulse));

  p_rise_sensed_r9: assert property (@(posedge clk) disable iff (rst)
    rise_pulse |-> ($past(scl_in) && !scl_oe));

  p_rise_single_r9: assert property (@(posedge clk) disable iff (rst)
    rise_pulse |=> !rise_pulse);
endmodule

bind scl_clkgen scl_clkgen_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .scl_in     (scl_in),
  .scl_oe     (scl_oe),
  .fall_pulse (fall_pulse),
  .rise_pulse (rise_pulse)
);

// File: tb/scl_clkgen_tb.sv
`timescale 1ns/1ps
module scl_clkgen_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [W-1:0] std_lo = '0, std_hi = '0, hs_lo = '0, hs_hi = '0;
  logic hs_sel = 1'b0;
  logic ext_low = 1'b0;
  logic scl_in, scl_oe, fall_pulse, rise_pulse;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign scl_in = !(scl_oe || ext_low);

  scl_clkgen #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .en(en),
    .std_lo(std_lo), .std_hi(std_hi), .hs_lo(hs_lo), .hs_hi(hs_hi),
    .hs_sel(hs_sel), .scl_in(scl_in), .scl_oe(scl_oe),
    .fall_pulse(fall_pulse), .rise_pulse(rise_pulse)
  );

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count consecutive sampled cycles with scl_oe == v; capture pulses at samples 1 and 2.
  task automatic measure(input logic v, output int n, output logic p1f, output logic p2r);
    n = 0; p1f = 0; p2r = 0;
    while (scl_oe == v && n < 1000) begin
      if (n == 0) p1f = fall_pulse;
      if (n == 1) p2r = rise_pulse;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic restart();
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic pf, pr;
    // R1 reset state
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    chk("R1 oe in reset", scl_oe, 0);
    chk("R1 pulses in reset", fall_pulse | rise_pulse, 0);
    en = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    // R2 R3 R5 R7 R8 R9 sweep
    for (int m = 0; m < 2; m++) begin
      for (int lo = 0; lo < 5; lo++) begin
        for (int hi = 0; hi < 5; hi++) begin
          en = 1'b0;
          hs_sel = m[0];
          if (m == 0) begin
            std_lo = W'(lo); std_hi = W'(hi); hs_lo = 8'd7; hs_hi = 8'd7;
          end else begin
            hs_lo = W'(lo); hs_hi = W'(hi); std_lo = 8'd7; std_hi = 8'd7;
          end
          restart();
          chk("R1 drive after enable", scl_oe, 1);
          measure(1'b1, n, pf, pr);
          chk("R8 fall pulse at enable", pf, 1);
          chk("R2 R5 R7 low run", n, eff(lo));
          measure(1'b0, n, pf, pr);
          chk("R3 R5 R7 released run", n, eff(hi) + 1);
          chk("R9 rise pulse", pr, 1);
          measure(1'b1, n, pf, pr);
          chk("R8 fall pulse after high", pf, 1);
          chk("R2 second low run", n, eff(lo));
        end
      end
    end

    // R3 stretch by external hold
    hs_sel = 1'b0; std_lo = 8'd2; std_hi = 8'd3;
    for (int s = 1; s < 5; s++) begin
      restart();
      ext_low = 1'b1;
      measure(1'b1, n, pf, pr);
      n = 0; pr = 0;
      while (scl_oe == 1'b0 && n < 1000) begin
        n++;
        if (n == s + 1) pr = rise_pulse;
        if (n == s) ext_low = 1'b0;
        @(negedge clk);
      end
      chk("R3 stretched released run", n, s + 3);
      chk("R9 rise after stretch", pr, 1);
    end

    // R4 external pull cuts high phase short
    std_lo = 8'd3; std_hi = 8'd9;
    for (int k = 2; k < 6; k++) begin
      restart();
      measure(1'b1, n, pf, pr);
      n = 0;
      while (scl_oe == 1'b0 && n < 1000) begin
        n++;
        if (n == k) ext_low = 1'b1;
        @(negedge clk);
      end
      chk("R4 cut released run", n, k);
      chk("R8 no fall pulse on external pull", fall_pulse, 0);
      ext_low = 1'b0;
      measure(1'b1, n, pf, pr);
      chk("R4 full low after cut", n, 3);
    end

    // R6 mode change mid-phase
    std_lo = 8'd3; std_hi = 8'd3; hs_lo = 8'd6; hs_hi = 8'd1; hs_sel = 1'b0;
    restart();
    hs_sel = 1'b1;
    measure(1'b1, n, pf, pr);
    chk("R6 low keeps old pair", n, 3);
    measure(1'b0, n, pf, pr);
    chk("R6 high keeps old pair", n, 4);
    measure(1'b1, n, pf, pr);
    chk("R6 next low uses new pair", n, 6);
    measure(1'b0, n, pf, pr);
    chk("R6 next high uses new pair", n, 2);

    // R1 disable mid-phase
    hs_sel = 1'b0; std_lo = 8'd6; std_hi = 8'd2;
    restart();
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R1 release on disable", scl_oe, 0);
    chk("R1 pulses clear on disable", fall_pulse | rise_pulse, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule